// File: doc/BRIEF.md
# Chained Descriptor DMA Channel Sequencer

This block walks a linked chain of copy descriptors held in a small internal descriptor store. A host writes the store and three control registers through one simple write/read port. Each descriptor gives a source address, a destination address, a byte count and a link to the next descriptor. For every descriptor the sequencer hands one memory-copy command to a separate copy engine over a request/acknowledge port. The copy engine moves the bytes and answers with an acknowledge, which may carry an error flag.

The chain begins at the descriptor named by the current-descriptor register. It starts when the host moves the start bit of the mode register from clear to set. It ends at a descriptor whose link word carries an end-of-list flag in bit 0. The chain also stops on a zero-length descriptor, on an error response, on an abort, or when the host clears the start bit. Sticky event bits in the status register, cleared by writing ones, record the reason the chain stopped. A single interrupt line reports the events whose enables are set.

Top module: `dma_chain_seq`

## Requirements
- R1: `host_addr` MSB = 1 selects the descriptor store: `host_addr[1:0]` picks the word (0 source, 1 destination, 2 next-link, 3 byte count) and the bits in between pick the slot. MSB = 0 selects a register by `host_addr[1:0]`: 0 mode, 1 status, 2 current-descriptor address. Reads return the stored word. The descriptor at byte address A sits in slot A[5+IDX_W-1:5].
- R2: The current-descriptor address is 32-byte aligned, so bits [4:0] always read as zero. Host writes to it are ignored while the channel is busy.
- R3: Mode bit 0 is start and bit 1 is abort. A chain starts only on a mode write that moves start from 0 to 1 with the abort bit written 0, while the channel is idle. A write that keeps start at 1 starts nothing, and hardware never clears the start bit.
- R4: For each descriptor, `cmd_req` rises with `cmd_src`, `cmd_dst` and `cmd_len` (the low LEN_W bits of the byte count) taken from that descriptor. They stay stable until `cmd_ack`. Status bit 0 (busy) is set from start until the chain stops.
- R5: When next-link bit 0 is clear, an acknowledged descriptor is followed by the one at next-link bits [31:5], and the current-descriptor register is updated to that address. A link word is read when its descriptor is fetched, so a chain can be extended by clearing the old tail's flag before that tail is fetched.
- R6: Acknowledging a descriptor whose next-link bit 0 is set raises end-of-links (status bit 2) and clears busy. Halted (status bit 1) is left clear.
- R7: A descriptor with a zero byte count issues no command. It raises programming error (status bit 3), clears busy and leaves the current-descriptor register on that descriptor.
- R8: An acknowledge with `cmd_err` set raises transfer error (status bit 4) and halted, and clears busy.
- R9: Setting abort, or clearing start, while busy withdraws any pending request and stops the chain with halted set and no end-of-links. Halted clears on the next accepted start.
- R10: Status bits 2 to 4 clear when a 1 is written to them. Writing 0 leaves them unchanged.
- R11: `irq` is high when (mode bit 2 and end-of-links) or (mode bit 3 and either programming error or transfer error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | IDX_W+3 | Host word address (region, slot, word) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| cmd_req | output | 1 | Copy command request |
| cmd_src | output | 32 | Copy source address |
| cmd_dst | output | 32 | Copy destination address |
| cmd_len | output | LEN_W | Copy length in bytes |
| cmd_ack | input | 1 | Copy engine acknowledge (command finished) |
| cmd_err | input | 1 | Error response, valid with cmd_ack |
| irq | output | 1 | Interrupt |

## Verification
Several rules are checked by assertions on every cycle. A pending request keeps its fields until it is acknowledged or withdrawn. A zero-length fetch never produces a request. An error response always leaves the channel idle. The walker only leaves idle on an accepted start. A locked current-descriptor register does not move, and a write-one clears an event bit. Other behaviour can only be shown by the bench scenarios, which run whole chains and compare the observed commands and register contents with values computed from the descriptors written. These scenarios cover link following, extending a chain while it runs, the absence of a restart without a start edge, the stop reasons with their status codes, and interrupt gating.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   localparam int WORD_W    = 32;
   localparam int ALIGN_LSB = 5;

   // mode register bits
   localparam int MB_START  = 0;
   localparam int MB_ABORT  = 1;
   localparam int MB_EOL_IE = 2;
   localparam int MB_ERR_IE = 3;
   localparam int MODE_W    = 4;

   // status register bits
   localparam int SB_BUSY = 0;
   localparam int SB_HALT = 1;
   localparam int SB_EOL  = 2;
   localparam int SB_PERR = 3;
   localparam int SB_TERR = 4;

   // register offsets
   localparam logic [1:0] RO_MODE = 2'd0;
   localparam logic [1:0] RO_STAT = 2'd1;
   localparam logic [1:0] RO_CDA  = 2'd2;

   // descriptor word numbers
   localparam int DW_SRC  = 0;
   localparam int DW_DST  = 1;
   localparam int DW_NEXT = 2;
   localparam int DW_CNT  = 3;
   localparam int DESC_WORDS = 4;

   typedef enum logic [1:0] {WK_IDLE, WK_FETCH, WK_ISSUE} walk_state_e;
endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store
   import dma_chain_pkg::*;
#(
   parameter int NSLOT = 8,
   localparam int IDX_W = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [1:0]        wr_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  h_slot,
   input  logic [1:0]        h_word,
   output logic [WORD_W-1:0] h_data,
   input  logic [IDX_W-1:0]  rd_slot,
   output logic [WORD_W-1:0] rd_src,
   output logic [WORD_W-1:0] rd_dst,
   output logic [WORD_W-1:0] rd_next,
   output logic [WORD_W-1:0] rd_cnt
);
   logic [WORD_W-1:0] walk_rd [DESC_WORDS];
   logic [WORD_W-1:0] host_rd [DESC_WORDS];

   for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] bank [NSLOT];
      always_ff @(posedge clk) begin
         if (wr_en && wr_word == 2'(w)) bank[wr_slot] <= wr_data;
      end
      assign walk_rd[w] = bank[rd_slot];
      assign host_rd[w] = bank[h_slot];
   end

   assign rd_src  = walk_rd[DW_SRC];
   assign rd_dst  = walk_rd[DW_DST];
   assign rd_next = walk_rd[DW_NEXT];
   assign rd_cnt  = walk_rd[DW_CNT];
   assign h_data  = host_rd[h_word];
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
   import dma_chain_pkg::*;
#(
   parameter int LEN_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_go,
   input  logic              mode_start,
   input  logic              mode_abort,
   input  logic [WORD_W-1:0] d_src,
   input  logic [WORD_W-1:0] d_dst,
   input  logic [WORD_W-1:0] d_next,
   input  logic [WORD_W-1:0] d_cnt,
   output logic              cmd_req,
   output logic [WORD_W-1:0] cmd_src,
   output logic [WORD_W-1:0] cmd_dst,
   output logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_ack,
   input  logic              cmd_err,
   output logic              busy,
   output logic              ev_eol,
   output logic              ev_perr,
   output logic              ev_terr,
   output logic              ev_halt,
   output logic              cda_load,
   output logic [WORD_W-1:0] cda_next
);
   walk_state_e       state, state_nx;
   logic [WORD_W-1:0] next_q;
   logic              stop, null_d;

   assign stop   = mode_abort || !mode_start;
   assign null_d = (d_cnt[LEN_W-1:0] == '0);

   always_comb begin
      state_nx = state;
      ev_eol   = 1'b0;
      ev_perr  = 1'b0;
      ev_terr  = 1'b0;
      ev_halt  = 1'b0;
      cda_load = 1'b0;
      case (state)
         WK_IDLE: if (start_go) state_nx = WK_FETCH;
         WK_FETCH: begin
            if (stop) begin
               ev_halt  = 1'b1;
               state_nx = WK_IDLE;
            end else if (null_d) begin
               ev_perr  = 1'b1;
               state_nx = WK_IDLE;
            end else begin
               state_nx = WK_ISSUE;
            end
         end
         WK_ISSUE: begin
            if (cmd_ack) begin
               if (cmd_err) begin
                  ev_terr  = 1'b1;
                  ev_halt  = 1'b1;
                  state_nx = WK_IDLE;
               end else if (next_q[0]) begin
                  ev_eol   = 1'b1;
                  state_nx = WK_IDLE;
               end else begin
                  cda_load = 1'b1;
                  state_nx = WK_FETCH;
               end
            end else if (stop) begin
               ev_halt  = 1'b1;
               state_nx = WK_IDLE;
            end
         end
         default: state_nx = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WK_IDLE;
         cmd_src <= '0;
         cmd_dst <= '0;
         cmd_len <= '0;
         next_q  <= '0;
      end else begin
         state <= state_nx;
         if (state == WK_FETCH) begin
            cmd_src <= d_src;
            cmd_dst <= d_dst;
            cmd_len <= d_cnt[LEN_W-1:0];
            next_q  <= d_next;
         end
      end
   end

   assign cmd_req  = (state == WK_ISSUE);
   assign busy     = (state != WK_IDLE);
   assign cda_next = next_q;

   // R4: a pending request keeps its fields until acknowledged or withdrawn
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack && !stop) |=>
         (cmd_req && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)));

   // R7: a null descriptor never turns into a request
   assert_null_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_FETCH && !stop && null_d) |=> (!cmd_req && !busy));

   // R8: an error response leaves the channel idle
   assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_ack && cmd_err) |=> !busy);

   // R3: idle is left only on an accepted start
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_IDLE && !start_go) |=> (state == WK_IDLE));
endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
   import dma_chain_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_off,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        rd_off,
   output logic [WORD_W-1:0] rd_data,
   input  logic              busy,
   input  logic              ev_eol,
   input  logic              ev_perr,
   input  logic              ev_terr,
   input  logic              ev_halt,
   input  logic              cda_load,
   input  logic [WORD_W-1:0] cda_next,
   output logic              mode_start,
   output logic              mode_abort,
   output logic              start_go,
   output logic [WORD_W-1:0] cda,
   output logic              irq
);
   localparam int CDA_W = WORD_W - ALIGN_LSB;

   logic [MODE_W-1:0] mode_q;
   logic [CDA_W-1:0]  cda_q;
   logic              eol_q, perr_q, terr_q, halt_q;
   logic              mode_wr, stat_wr, cda_wr, irq_c;

   assign mode_wr  = wr_en && (wr_off == RO_MODE);
   assign stat_wr  = wr_en && (wr_off == RO_STAT);
   assign cda_wr   = wr_en && (wr_off == RO_CDA) && !busy;
   assign start_go = mode_wr && wr_data[MB_START] && !wr_data[MB_ABORT]
                     && !mode_q[MB_START] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         cda_q  <= '0;
         eol_q  <= 1'b0;
         perr_q <= 1'b0;
         terr_q <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         if (mode_wr) mode_q <= wr_data[MODE_W-1:0];
         if (cda_load)    cda_q <= cda_next[WORD_W-1:ALIGN_LSB];
         else if (cda_wr) cda_q <= wr_data[WORD_W-1:ALIGN_LSB];
         eol_q  <= ev_eol  | (eol_q  & ~(stat_wr & wr_data[SB_EOL]));
         perr_q <= ev_perr | (perr_q & ~(stat_wr & wr_data[SB_PERR]));
         terr_q <= ev_terr | (terr_q & ~(stat_wr & wr_data[SB_TERR]));
         if (ev_halt)       halt_q <= 1'b1;
         else if (start_go) halt_q <= 1'b0;
      end
   end

   assign mode_start = mode_q[MB_START];
   assign mode_abort = mode_q[MB_ABORT];
   assign cda        = {cda_q, {ALIGN_LSB{1'b0}}};

   always_comb begin
      case (rd_off)
         RO_MODE: rd_data = {{(WORD_W-MODE_W){1'b0}}, mode_q};
         RO_STAT: rd_data = {{(WORD_W-5){1'b0}}, terr_q, perr_q, eol_q, halt_q, busy};
         RO_CDA:  rd_data = cda;
         default: rd_data = '0;
      endcase
   end

   assign irq_c = (mode_q[MB_EOL_IE] & eol_q) | (mode_q[MB_ERR_IE] & (perr_q | terr_q));

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   // R2: a write while busy leaves the descriptor pointer alone
   assert_cda_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == RO_CDA && busy && !cda_load) |=> $stable(cda_q));

   // R10: write-one clears an event bit when no new event arrives
   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_data[SB_EOL] && !ev_eol) |=> !eol_q);

   // R9: a stop event always shows as halted
   assert_halt_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_halt |=> halt_q);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_chain_pkg::*;
#(
   parameter int NSLOT   = 8,
   parameter int LEN_W   = 24,
   parameter bit IRQ_REG = 1'b0,
   localparam int IDX_W   = $clog2(NSLOT),
   localparam int HOST_AW = IDX_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               cmd_req,
   output logic [31:0]        cmd_src,
   output logic [31:0]        cmd_dst,
   output logic [LEN_W-1:0]   cmd_len,
   input  logic               cmd_ack,
   input  logic               cmd_err,
   output logic               irq
);
   if (NSLOT < 2 || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_nslot
      $error("NSLOT must be a power of two of at least 2");
   end
   if (LEN_W < 1 || LEN_W > WORD_W) begin : g_bad_len
      $error("LEN_W must lie in 1..32");
   end
   if (IDX_W + ALIGN_LSB > WORD_W) begin : g_bad_idx
      $error("descriptor store too large for the address word");
   end

   logic              mem_sel;
   logic [IDX_W-1:0]  h_slot;
   logic [1:0]        h_word;
   logic [WORD_W-1:0] mem_rd, reg_rd;
   logic [WORD_W-1:0] d_src, d_dst, d_next, d_cnt;
   logic [WORD_W-1:0] cda, cda_next;
   logic              busy, start_go, mode_start, mode_abort;
   logic              ev_eol, ev_perr, ev_terr, ev_halt, cda_load;

   assign mem_sel = host_addr[HOST_AW-1];
   assign h_slot  = host_addr[HOST_AW-2:2];
   assign h_word  = host_addr[1:0];

   dma_desc_store #(.NSLOT(NSLOT)) u_store (
      .clk     (clk),
      .wr_en   (host_we && mem_sel),
      .wr_slot (h_slot),
      .wr_word (h_word),
      .wr_data (host_wdata),
      .h_slot  (h_slot),
      .h_word  (h_word),
      .h_data  (mem_rd),
      .rd_slot (cda[ALIGN_LSB+IDX_W-1:ALIGN_LSB]),
      .rd_src  (d_src),
      .rd_dst  (d_dst),
      .rd_next (d_next),
      .rd_cnt  (d_cnt)
   );

   dma_chain_walker #(.LEN_W(LEN_W)) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_go   (start_go),
      .mode_start (mode_start),
      .mode_abort (mode_abort),
      .d_src      (d_src),
      .d_dst      (d_dst),
      .d_next     (d_next),
      .d_cnt      (d_cnt),
      .cmd_req    (cmd_req),
      .cmd_src    (cmd_src),
      .cmd_dst    (cmd_dst),
      .cmd_len    (cmd_len),
      .cmd_ack    (cmd_ack),
      .cmd_err    (cmd_err),
      .busy       (busy),
      .ev_eol     (ev_eol),
      .ev_perr    (ev_perr),
      .ev_terr    (ev_terr),
      .ev_halt    (ev_halt),
      .cda_load   (cda_load),
      .cda_next   (cda_next)
   );

   dma_chain_regs #(.IRQ_REG(IRQ_REG)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (host_we && !mem_sel),
      .wr_off     (host_addr[1:0]),
      .wr_data    (host_wdata),
      .rd_off     (host_addr[1:0]),
      .rd_data    (reg_rd),
      .busy       (busy),
      .ev_eol     (ev_eol),
      .ev_perr    (ev_perr),
      .ev_terr    (ev_terr),
      .ev_halt    (ev_halt),
      .cda_load   (cda_load),
      .cda_next   (cda_next),
      .mode_start (mode_start),
      .mode_abort (mode_abort),
      .start_go   (start_go),
      .cda        (cda),
      .irq        (irq)
   );

   assign host_rdata = mem_sel ? mem_rd : reg_rd;
endmodule

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        cmd_req;
   logic [31:0] cmd_src, cmd_dst;
   logic [23:0] cmd_len;
   logic        cmd_ack = 1'b0;
   logic        cmd_err = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dma_chain_seq uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_req(cmd_req),
      .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
      .cmd_ack(cmd_ack), .cmd_err(cmd_err), .irq(irq)
   );

   localparam logic [1:0] MODE = 2'd0, STAT = 2'd1, CDA = 2'd2;

   function automatic logic [5:0] da(input int slot, input int w);
      return {1'b1, 3'(slot), 2'(w)};
   endfunction
   function automatic logic [5:0] ra(input logic [1:0] off);
      return {4'b0000, off};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic put_desc(input int slot, input logic [31:0] s, input logic [31:0] t,
                           input logic [31:0] n, input logic [31:0] c);
      wr(da(slot, 0), s);
      wr(da(slot, 1), t);
      wr(da(slot, 2), n);
      wr(da(slot, 3), c);
   endtask

   task automatic wait_req(input string tag);
      int n = 0;
      while (!cmd_req && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(tag, "request seen", {31'b0, cmd_req}, 32'd1);
   endtask

   task automatic ack(input logic e);
      cmd_ack = 1'b1; cmd_err = e;
      @(posedge clk);
      @(negedge clk);
      cmd_ack = 1'b0; cmd_err = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(ra(MODE), d); chk("R3", "reset mode", d, 0);
      rd(ra(STAT), d); chk("R4", "reset status", d, 0);
      rd(ra(CDA), d);  chk("R2", "reset cda", d, 0);
      chk("R11", "reset irq", {31'b0, irq}, 0);
      chk("R4", "reset req", {31'b0, cmd_req}, 0);
   endtask

   task automatic t_map;
      logic [31:0] d;
      wr(da(3, 1), 32'h0000_A5A5);
      rd(da(3, 1), d); chk("R1", "store readback", d, 32'h0000_A5A5);
      wr(ra(CDA), 32'h1234_567F);
      rd(ra(CDA), d); chk("R2", "cda aligned", d, 32'h1234_5660);
      wr(ra(CDA), 32'h0);
   endtask

   task automatic t_chain;
      logic [31:0] d, s0;
      for (int i = 0; i < 3; i++)
         put_desc(i, 32'h1000 + i * 32'h100, 32'h8000 + i * 32'h100,
                  (i == 2) ? 32'h1 : 32'((i + 1) * 32), 32'h40 * (i + 1));
      wr(ra(MODE), 32'h5);
      rd(ra(STAT), d); chk("R4", "busy after start", d & 32'h1, 1);
      for (int i = 0; i < 3; i++) begin
         wait_req("R4");
         chk("R4", "src", cmd_src, 32'h1000 + i * 32'h100);
         chk("R4", "dst", cmd_dst, 32'h8000 + i * 32'h100);
         chk("R4", "len", {8'b0, cmd_len}, 32'h40 * (i + 1));
         if (i == 0) begin
            s0 = cmd_src;
            repeat (3) @(negedge clk);
            chk("R4", "req held", {31'b0, cmd_req}, 1);
            chk("R4", "src held", cmd_src, s0);
         end
         ack(1'b0);
         if (i == 0) begin
            rd(ra(CDA), d); chk("R5", "cda follows link", d, 32'h20);
         end
      end
      rd(ra(STAT), d); chk("R6", "end-of-links status", d, 32'h4);
      rd(ra(CDA), d);  chk("R5", "cda on tail", d, 32'h40);
      chk("R11", "irq on eol", {31'b0, irq}, 1);
   endtask

   task automatic t_no_restart;
      logic [31:0] d;
      wr(ra(MODE), 32'h5);
      repeat (4) @(negedge clk);
      chk("R3", "no restart req", {31'b0, cmd_req}, 0);
      rd(ra(STAT), d); chk("R3", "no restart busy", d & 32'h1, 0);
      rd(ra(MODE), d); chk("R3", "start kept", d, 32'h5);
      wr(ra(MODE), 32'h1);
      chk("R11", "irq gated off", {31'b0, irq}, 0);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      wr(ra(STAT), 32'h0);
      rd(ra(STAT), d); chk("R10", "write zero keeps", d, 32'h4);
      wr(ra(STAT), 32'h4);
      rd(ra(STAT), d); chk("R10", "write one clears", d, 32'h0);
   endtask

   task automatic t_append;
      logic [31:0] d;
      put_desc(4, 32'h4400, 32'h9400, 32'hA0, 32'h4);
      put_desc(5, 32'h5500, 32'h9500, 32'h1, 32'h5);
      put_desc(6, 32'h6600, 32'h9600, 32'h1, 32'h6);
      wr(ra(MODE), 32'h0);
      wr(ra(CDA), 32'h80);
      wr(ra(MODE), 32'h1);
      wait_req("R5");
      chk("R5", "append first", cmd_src, 32'h4400);
      wr(da(5, 2), 32'hC0);
      ack(1'b0);
      wait_req("R5");
      chk("R5", "append second", cmd_src, 32'h5500);
      ack(1'b0);
      wait_req("R5");
      chk("R5", "appended tail", cmd_src, 32'h6600);
      ack(1'b0);
      rd(ra(STAT), d); chk("R6", "append eol", d, 32'h4);
      wr(ra(STAT), 32'h4);
   endtask

   task automatic t_null;
      logic [31:0] d;
      put_desc(7, 32'h7700, 32'h9700, 32'h1, 32'h0);
      wr(ra(MODE), 32'h0);
      wr(ra(CDA), 32'hE0);
      wr(ra(MODE), 32'h9);
      repeat (4) @(negedge clk);
      chk("R7", "null no req", {31'b0, cmd_req}, 0);
      rd(ra(STAT), d); chk("R7", "prog error status", d, 32'h8);
      rd(ra(CDA), d);  chk("R7", "cda stays", d, 32'hE0);
      chk("R11", "irq on prog error", {31'b0, irq}, 1);
      wr(ra(STAT), 32'h8);
   endtask

   task automatic t_xfer_err;
      logic [31:0] d;
      put_desc(0, 32'hAA00, 32'hBB00, 32'h1, 32'h10);
      wr(ra(MODE), 32'h0);
      wr(ra(CDA), 32'h0);
      wr(ra(MODE), 32'h9);
      wait_req("R8");
      ack(1'b1);
      rd(ra(STAT), d); chk("R8", "transfer error status", d, 32'h12);
      chk("R11", "irq on transfer error", {31'b0, irq}, 1);
      wr(ra(STAT), 32'h10);
      rd(ra(STAT), d); chk("R10", "error cleared", d, 32'h2);
      chk("R11", "irq after clear", {31'b0, irq}, 0);
   endtask

   task automatic t_abort;
      logic [31:0] d;
      wr(ra(MODE), 32'h0);
      wr(ra(MODE), 32'h1);
      rd(ra(STAT), d); chk("R9", "halted cleared on start", d, 32'h1);
      wait_req("R9");
      wr(ra(MODE), 32'h3);
      repeat (2) @(negedge clk);
      chk("R9", "abort withdraws req", {31'b0, cmd_req}, 0);
      rd(ra(STAT), d); chk("R9", "abort status", d, 32'h2);
      wr(ra(MODE), 32'h0);
      wr(ra(MODE), 32'h1);
      wait_req("R9");
      wr(ra(CDA), 32'h60);
      rd(ra(CDA), d); chk("R2", "cda locked while busy", d, 32'h0);
      wr(ra(MODE), 32'h0);
      repeat (2) @(negedge clk);
      chk("R9", "clear start withdraws", {31'b0, cmd_req}, 0);
      rd(ra(STAT), d); chk("R9", "clear start status", d, 32'h2);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_chain();
      t_no_restart();
      t_w1c();
      t_append();
      t_null();
      t_xfer_err();
      t_abort();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule